// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steers a 16-bit processor into and back out of a device interrupt handler. It is sampled at instruction boundaries. When a device request qualifies, it banks the stack pointer, pushes the program counter and status word onto the supervisor stack and derives the handler status word. It then reads the handler address from a vector table. When a return-from-interrupt instruction completes, it unwinds the frame in the opposite order. All stack and table traffic goes over a request/ready memory port.

The processor presents its current PC, status word (PSW) and R6 (stack pointer) at the boundary. When a sequence finishes, the block issues a one-cycle update strobe carrying the new PC, PSW and R6. The processor loads these values before it fetches its next instruction.

PSW layout used throughout:
- Bit 15 = 1 means user mode.
- Bits 10:8 hold the running priority level, 0 to 7.
- Bits 2:0 hold the condition codes.

Top module: `irq_sequencer`

## Requirements
- R1: After a synchronous reset, busy, mem_req, upd_valid and irq_ack are all 0.
- R2: An interrupt starts only when all of these hold at a boundary cycle while the block is idle: dev_req=1, dev_en=1, and dev_prio is strictly greater than PSW bits 10:8. Otherwise no sequence starts and no memory access is made.
- R3: A request whose priority is equal to or below the running level is not lost. If the device holds it, it is taken at the first boundary after the level has dropped below it.
- R4: On entry from user mode (PSW bit 15 = 1), R6 is saved in a held user pointer and the supervisor pointer (reset value 0x3000) becomes the stack. From privileged mode, R6 itself is the stack.
- R5: Entry writes the old PSW to stack-1, then the old PC to stack-2. R6 at update equals stack-2.
- R6: The entry PSW has bit 15 cleared, bits 10:8 set to dev_prio and bits 2:0 cleared. All other bits are kept.
- R7: After the pushes, one read is made at address 0x0100 plus the zero-extended 8-bit vector. The word read becomes the new PC.
- R8: A return reads the PC at R6, then the PSW at R6+1. If the popped PSW has bit 15 = 1, R6+2 is stored as the supervisor pointer and R6 is restored from the user pointer. Otherwise R6 becomes R6+2.
- R9: A memory request keeps its address, direction and write data unchanged until mem_rdy is seen. The access completes in the cycle in which mem_req and mem_rdy are both 1.
- R10: irq_ack and upd_valid are one-cycle pulses. irq_ack follows an accepted interrupt by one cycle. upd_valid ends every sequence.
- R11: When rti_req and a qualifying request meet at the same boundary, the return is performed first.
- R12: Boundary strobes that arrive while busy is 1, including the update cycle, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Completing instruction is a return from interrupt |
| dev_req | input | 1 | Device interrupt request (level) |
| dev_en | input | 1 | Device interrupt enable |
| dev_prio | input | 3 | Device priority level |
| dev_vec | input | 8 | Device vector number |
| psw_in | input | 16 | Current program status word |
| pc_in | input | 16 | Current program counter |
| r6_in | input | 16 | Current stack pointer register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Access completes this cycle |
| busy | output | 1 | A sequence is in progress |
| irq_ack | output | 1 | Pulse: interrupt accepted |
| upd_valid | output | 1 | Pulse: load the values below |
| pc_out | output | 16 | New program counter |
| psw_out | output | 16 | New status word |
| r6_out | output | 16 | New stack pointer register |

## Verification
A wrong internal state surfaces at the memory port. A bad stack pointer or banking decision shows up as a wrong push or pop address on the very next access, two to four cycles after the boundary. A bad PSW or PC shows up on the update strobe that ends the sequence. The damage then reappears in the addresses used by the next nested entry or return.

Every completed memory access and every update is compared against a behavioural model, as is busy and irq_ack on each clock. A wrong user or supervisor pointer may stay hidden until the return that uses it, so the stimulus nests interrupts and then unwinds them fully.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int PSW_W    = 16;
  localparam int PRIV_BIT = 15;
  localparam int LVL_HI   = 10;
  localparam int LVL_LO   = 8;
  localparam int LVL_W    = LVL_HI - LVL_LO + 1;
  localparam int CC_W     = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PSW,
    ST_PUSH_PC,
    ST_VEC_RD,
    ST_POP_PC,
    ST_POP_PSW,
    ST_UPDATE
  } seq_state_t;

  function automatic logic [PSW_W-1:0] entry_psw(input logic [PSW_W-1:0] old_psw,
                                                 input logic [LVL_W-1:0] lvl);
    logic [PSW_W-1:0] p;
    p = old_psw;
    p[PRIV_BIT] = 1'b0;
    p[LVL_HI:LVL_LO] = lvl;
    p[CC_W-1:0] = '0;
    return p;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int LW = 3
) (
  input  logic          idle,
  input  logic          boundary,
  input  logic          rti_req,
  input  logic          dev_req,
  input  logic          dev_en,
  input  logic [LW-1:0] dev_prio,
  input  logic [LW-1:0] cur_lvl,
  output logic          go_int,
  output logic          go_rti
);
  logic window;
  logic qualifies;

  always_comb begin
    window    = idle && boundary;
    qualifies = dev_req && dev_en && (dev_prio > cur_lvl);
    go_rti    = window && rti_req;
    go_int    = window && !rti_req && qualifies;
  end
endmodule

// File: rtl/sp_bank.sv
module sp_bank #(
  parameter int          DW        = 16,
  parameter logic [15:0] SSP_RESET = 16'h3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          save_usp,
  input  logic [DW-1:0] usp_d,
  input  logic          save_ssp,
  input  logic [DW-1:0] ssp_d,
  output logic [DW-1:0] usp_q,
  output logic [DW-1:0] ssp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      usp_q <= '0;
      ssp_q <= DW'(SSP_RESET);
    end else begin
      if (save_usp) usp_q <= usp_d;
      if (save_ssp) ssp_q <= ssp_d;
    end
  end

  AST_BANK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(save_usp && save_ssp)); // R4
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          VW        = 8,
  parameter logic [15:0] VEC_BASE  = 16'h0100,
  parameter logic [15:0] SSP_RESET = 16'h3000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          rti_req,
  input  logic          dev_req,
  input  logic          dev_en,
  input  logic [2:0]    dev_prio,
  input  logic [VW-1:0] dev_vec,
  input  logic [15:0]   psw_in,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   r6_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_rdy,
  output logic          busy,
  output logic          irq_ack,
  output logic          upd_valid,
  output logic [15:0]   pc_out,
  output logic [15:0]   psw_out,
  output logic [15:0]   r6_out
);
  localparam logic [15:0] ONE = 16'd1;

  seq_state_t    state;
  logic [15:0]   sp;
  logic [15:0]   pc_w, psw_w, r6_w, old_psw;
  logic [VW-1:0] vec_q;
  logic          was_entry;
  logic          go_int, go_rti;
  logic          idle, done;
  logic [15:0]   usp_q, ssp_q;
  logic [15:0]   base_sp, sp_up;
  logic          save_usp, save_ssp;

  assign idle    = (state == ST_IDLE);
  assign busy    = !idle;
  assign done    = mem_req && mem_rdy;
  assign pc_out  = pc_w;
  assign psw_out = psw_w;
  assign r6_out  = r6_w;

  irq_gate #(.LW(LVL_W)) u_gate (
    .idle     (idle),
    .boundary (boundary),
    .rti_req  (rti_req),
    .dev_req  (dev_req),
    .dev_en   (dev_en),
    .dev_prio (dev_prio),
    .cur_lvl  (psw_in[LVL_HI:LVL_LO]),
    .go_int   (go_int),
    .go_rti   (go_rti)
  );

  always_comb begin
    base_sp  = psw_in[PRIV_BIT] ? ssp_q : r6_in;
    sp_up    = sp + ONE;
    save_usp = go_int && psw_in[PRIV_BIT];
    save_ssp = (state == ST_POP_PSW) && done && mem_rdata[PRIV_BIT];
  end

  sp_bank #(.DW(16), .SSP_RESET(SSP_RESET)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .save_usp (save_usp),
    .usp_d    (r6_in),
    .save_ssp (save_ssp),
    .ssp_d    (sp_up),
    .usp_q    (usp_q),
    .ssp_q    (ssp_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sp        <= '0;
      pc_w      <= '0;
      psw_w     <= '0;
      r6_w      <= '0;
      old_psw   <= '0;
      vec_q     <= '0;
      was_entry <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      irq_ack   <= 1'b0;
      upd_valid <= 1'b0;
    end else begin
      irq_ack   <= 1'b0;
      upd_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go_rti) begin
            sp        <= r6_in;
            mem_req   <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= r6_in;
            was_entry <= 1'b0;
            state     <= ST_POP_PC;
          end else if (go_int) begin
            sp        <= base_sp - ONE;
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= base_sp - ONE;
            mem_wdata <= psw_in;
            pc_w      <= pc_in;
            old_psw   <= psw_in;
            psw_w     <= entry_psw(psw_in, dev_prio);
            vec_q     <= dev_vec;
            was_entry <= 1'b1;
            irq_ack   <= 1'b1;
            state     <= ST_PUSH_PSW;
          end
        end
        ST_PUSH_PSW: if (done) begin
          sp        <= sp - ONE;
          mem_addr  <= sp - ONE;
          mem_wdata <= pc_w;
          state     <= ST_PUSH_PC;
        end
        ST_PUSH_PC: if (done) begin
          mem_we   <= 1'b0;
          mem_addr <= VEC_BASE + 16'(vec_q);
          state    <= ST_VEC_RD;
        end
        ST_VEC_RD: if (done) begin
          pc_w      <= mem_rdata;
          r6_w      <= sp;
          mem_req   <= 1'b0;
          upd_valid <= 1'b1;
          state     <= ST_UPDATE;
        end
        ST_POP_PC: if (done) begin
          pc_w     <= mem_rdata;
          sp       <= sp_up;
          mem_addr <= sp_up;
          state    <= ST_POP_PSW;
        end
        ST_POP_PSW: if (done) begin
          psw_w     <= mem_rdata;
          r6_w      <= mem_rdata[PRIV_BIT] ? usp_q : sp_up;
          mem_req   <= 1'b0;
          upd_valid <= 1'b1;
          state     <= ST_UPDATE;
        end
        ST_UPDATE: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack); // R10
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> !upd_valid); // R10
  AST_ACK_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ack) |-> ($past(dev_prio) > $past(psw_in[LVL_HI:LVL_LO]))); // R2
  AST_ENTRY_PSW: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && was_entry) |-> (!psw_out[PRIV_BIT] && psw_out[CC_W-1:0] == '0)); // R6
  AST_ENTRY_FRAME: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && was_entry && old_psw[PRIV_BIT]) |-> (r6_out == ssp_q - 16'd2)); // R5
  AST_RET_USER: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !was_entry && psw_out[PRIV_BIT]) |-> (r6_out == usp_q)); // R8
endmodule

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] SSP0 = 16'h3000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic boundary = 1'b0, rti_req = 1'b0;
  logic dev_req = 1'b0, dev_en = 1'b0;
  logic [2:0] dev_prio = '0;
  logic [7:0] dev_vec = '0;
  logic [15:0] cpu_psw = 16'h8002, cpu_pc = 16'h3000, cpu_r6 = 16'hF000;
  logic mem_req, mem_we, mem_rdy = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic busy, irq_ack, upd_valid;
  logic [15:0] pc_out, psw_out, r6_out;

  int errors = 0, checks = 0;
  bit fast_rdy = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_sequencer #(.SSP_RESET(SSP0)) uut (
    .clk(clk), .rst(rst), .boundary(boundary), .rti_req(rti_req),
    .dev_req(dev_req), .dev_en(dev_en), .dev_prio(dev_prio), .dev_vec(dev_vec),
    .psw_in(cpu_psw), .pc_in(cpu_pc), .r6_in(cpu_r6),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_rdy(mem_rdy),
    .busy(busy), .irq_ack(irq_ack), .upd_valid(upd_valid),
    .pc_out(pc_out), .psw_out(psw_out), .r6_out(r6_out)
  );

  logic [15:0] mem [logic [15:0]];

  function automatic logic [15:0] rd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return 16'h4000 ^ {a[7:0], 8'h35};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model state
  bit m_busy = 0, ack_exp = 0, pend = 0;
  logic [15:0] p_addr, p_wdata;
  logic p_we;
  logic [15:0] m_usp = '0, m_ssp = SSP0;
  logic [15:0] e_pc, e_psw, e_r6;
  logic q_we[$];
  logic [15:0] q_addr[$], q_data[$];
  string q_tag[$];

  task automatic expect_acc(input logic we, input logic [15:0] a, input logic [15:0] d, input string t);
    q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  always @(posedge clk) begin
    if (!rst) begin
      ack_exp = 0;
      pend = mem_req && !mem_rdy;
      p_addr = mem_addr; p_we = mem_we; p_wdata = mem_wdata;
      if (mem_req && mem_rdy) begin
        if (q_we.size() == 0) begin
          chk(0, "R2 unexpected access", mem_addr, 16'h0);
        end else begin
          chk(mem_we == q_we[0], {q_tag[0], " dir"}, 16'(mem_we), 16'(q_we[0]));
          chk(mem_addr == q_addr[0], {q_tag[0], " addr"}, mem_addr, q_addr[0]);
          if (q_we[0]) chk(mem_wdata == q_data[0], {q_tag[0], " data"}, mem_wdata, q_data[0]);
          void'(q_we.pop_front()); void'(q_addr.pop_front());
          void'(q_data.pop_front()); void'(q_tag.pop_front());
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
      end
      if (upd_valid) begin
        chk(m_busy && q_we.size() == 0, "R10 update timing", 16'(upd_valid), 16'(m_busy));
        chk(pc_out == e_pc, "R7/R8 pc_out", pc_out, e_pc);
        chk(psw_out == e_psw, "R6/R8 psw_out", psw_out, e_psw);
        chk(r6_out == e_r6, "R5/R8 r6_out", r6_out, e_r6);
        cpu_pc <= e_pc; cpu_psw <= e_psw; cpu_r6 <= e_r6;
        m_busy = 0;
      end else if (!m_busy && boundary) begin
        logic [15:0] s;
        if (rti_req) begin // R11: return wins
          s = cpu_r6;
          e_pc = rd(s);
          e_psw = rd(s + 16'd1);
          expect_acc(0, s, 16'h0, "R8 pop pc");
          expect_acc(0, s + 16'd1, 16'h0, "R8 pop psw");
          if (e_psw[15]) begin m_ssp = s + 16'd2; e_r6 = m_usp; end
          else e_r6 = s + 16'd2;
          m_busy = 1;
        end else if (dev_req && dev_en && dev_prio > cpu_psw[10:8]) begin
          if (cpu_psw[15]) begin m_usp = cpu_r6; s = m_ssp; end // R4
          else s = cpu_r6;
          expect_acc(1, s - 16'd1, cpu_psw, "R5 push psw");
          expect_acc(1, s - 16'd2, cpu_pc, "R5 push pc");
          expect_acc(0, 16'h0100 + 16'(dev_vec), 16'h0, "R7 vector");
          e_pc = rd(16'h0100 + 16'(dev_vec));
          e_psw = {1'b0, cpu_psw[14:11], dev_prio, cpu_psw[7:3], 3'b000};
          e_r6 = s - 16'd2;
          m_busy = 1;
          ack_exp = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == m_busy, "R12 busy", 16'(busy), 16'(m_busy));
      chk(irq_ack == ack_exp, "R10 irq_ack", 16'(irq_ack), 16'(ack_exp));
      if (pend) begin
        chk(mem_req && mem_addr == p_addr && mem_we == p_we && mem_wdata == p_wdata,
            "R9 request held", mem_addr, p_addr);
      end
      mem_rdy = fast_rdy ? 1'b1 : (($urandom % 3) != 0);
    end
    mem_rdata = rd(mem_addr);
  end

  task automatic set_dev(input logic r, input logic e, input logic [2:0] p, input logic [7:0] v);
    dev_req = r; dev_en = e; dev_prio = p; dev_vec = v;
  endtask

  task automatic bnd(input logic rti);
    @(negedge clk); boundary = 1'b1; rti_req = rti;
    @(negedge clk); boundary = 1'b0; rti_req = 1'b0;
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !upd_valid && !irq_ack, "R1 reset outputs",
        {12'h0, busy, mem_req, upd_valid, irq_ack}, 16'h0);
    rst = 1'b0;
    set_dev(0, 1, 3'd3, 8'h03);
    bnd(0);
    chk(cpu_psw == 16'h8002, "R2 no request no entry", cpu_psw, 16'h8002);
    set_dev(1, 0, 3'd3, 8'h03);
    bnd(0);
    chk(cpu_psw == 16'h8002, "R2 disabled no entry", cpu_psw, 16'h8002);
    set_dev(1, 1, 3'd3, 8'h03);
    bnd(0);
    chk(cpu_r6 == 16'h2FFE, "R4 user swap r6", cpu_r6, 16'h2FFE);
    chk(cpu_psw == 16'h0300, "R6 entry psw", cpu_psw, 16'h0300);
    chk(cpu_pc == (16'h4000 ^ 16'h0335), "R7 handler pc", cpu_pc, 16'h4000 ^ 16'h0335);
    set_dev(1, 1, 3'd2, 8'h07);
    bnd(0);
    chk(cpu_psw == 16'h0300, "R3 lower held off", cpu_psw, 16'h0300);
    set_dev(1, 1, 3'd3, 8'h07);
    bnd(0);
    chk(cpu_psw == 16'h0300, "R3 equal held off", cpu_psw, 16'h0300);
    fast_rdy = 1'b1;
    set_dev(1, 1, 3'd6, 8'h10);
    bnd(0);
    chk(cpu_r6 == 16'h2FFC, "R4 privileged no swap", cpu_r6, 16'h2FFC);
    fast_rdy = 1'b0;
    set_dev(0, 0, 3'd0, 8'h00);
    bnd(1);
    chk(cpu_r6 == 16'h2FFE && cpu_psw == 16'h0300, "R8 return to privileged", cpu_r6, 16'h2FFE);
    set_dev(1, 1, 3'd2, 8'h21);
    bnd(1);
    chk(cpu_r6 == 16'hF000 && cpu_psw == 16'h8002, "R8 return to user", cpu_r6, 16'hF000);
    chk(cpu_pc == 16'h3000, "R8 pc restored", cpu_pc, 16'h3000);
    bnd(0);
    chk(cpu_psw == 16'h0200 && cpu_r6 == 16'h2FFE, "R3 pending taken", cpu_psw, 16'h0200);
    set_dev(1, 1, 3'd5, 8'h44);
    @(negedge clk); boundary = 1'b1;
    repeat (30) @(negedge clk);
    boundary = 1'b0;
    while (m_busy) @(negedge clk);
    chk(cpu_psw[10:8] == 3'd5 && cpu_r6 == 16'h2FFC, "R12 single entry under held boundary",
        cpu_r6, 16'h2FFC);
    bnd(1);
    set_dev(1, 1, 3'd7, 8'h55);
    bnd(1);
    chk(cpu_psw == 16'h8002, "R11 return first", cpu_psw, 16'h8002);
    bnd(0);
    chk(cpu_psw == 16'h0700, "R11 then interrupt", cpu_psw, 16'h0700);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule